// File: doc/BRIEF.md
# Overhead Field Persistence Monitor

This block watches a single overhead field that appears once in every received frame. A frame strobe marks the cycle in which the field bytes are valid. A build parameter picks the field. It can be a single 8-bit trace byte, a single 8-bit fault-location byte, or a 13-bit protection-switch field. The protection-switch field is one whole byte followed by the upper five bits of the byte after it.

An incoming value does not take effect at once. The monitor tracks the most recently seen value as a candidate and counts how many frames in a row it has appeared. The candidate becomes the accepted value only when that run reaches a programmable persistence count. The fault-location variant also keeps the accepted value that was replaced. Each change of the accepted value sets a sticky change flag. The flag stays set until the host clears it, and it drives an interrupt output through a mask bit.

Top module: `ohm_persist_mon`

## Requirements
- R1: After reset the accepted value, the previous value and the change flag are all zero.
- R2: A new value becomes the accepted value at the strobe on which it has been seen in N consecutive strobed frames, where N is `persist_cfg` (1 to 15). It becomes visible on `acc_value` one clock after that strobe, and not earlier.
- R3: A `persist_cfg` of 0 behaves as 1: a new value is accepted on its first strobed frame.
- R4: A strobed value that differs from the candidate restarts the run at one, so an interrupted run is never accepted.
- R5: A run of the value that is already accepted never changes the accepted value, never sets the change flag and never updates the previous value.
- R6: With `FIELD_SEL`=1 (fault location), each acceptance copies the replaced accepted value into `prev_value`. With any other `FIELD_SEL`, `prev_value` reads zero.
- R7: With `FIELD_SEL`=2 (protection), the field is {`ovh_a[7:0]`, `ovh_b[7:3]`}, with `ovh_a` in the upper bits. With `FIELD_SEL`=0 or 1, the field is `ovh_a` and `ovh_b` has no effect.
- R8: Each acceptance sets `chg_flag`. The flag stays set until a cycle with `chg_clear` high and no acceptance.
- R9: When an acceptance and `chg_clear` happen in the same cycle, the flag ends up set.
- R10: `chg_irq` is high exactly when `chg_flag` is high and `chg_mask` is low.
- R11: Cycles with `frame_stb` low change neither the candidate run nor the accepted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Field bytes valid this cycle, one pulse per frame |
| ovh_a | input | 8 | First field byte |
| ovh_b | input | 8 | Following byte, upper 5 bits used by the protection variant |
| persist_cfg | input | 4 | Required consecutive-match count, 0 behaves as 1 |
| chg_mask | input | 1 | Masks the change interrupt when high |
| chg_clear | input | 1 | Clears the sticky change flag |
| acc_value | output | FW (13 or 8) | Currently accepted value |
| prev_value | output | FW (13 or 8) | Previously accepted value (fault variant), else zero |
| chg_flag | output | 1 | Sticky change indication |
| chg_irq | output | 1 | Change flag gated by the mask |

## Verification
Several properties are checked on every cycle. The accepted value moves only on a strobed cycle. The run count is live after every strobe. Every acceptance sets the flag, even when a clear arrives in the same cycle. The flag falls only on a clear. In the history variant, the previous value always equals the accepted value that was just replaced. Other behaviour can only be shown by the bench's scenarios, because it depends on sequences of frames: the exact frame on which a run of each persistence setting is accepted, the restart after an interrupted run, the silence for a repeated accepted value, and the field assembly of each variant.

// File: rtl/ohm_pkg.sv
package ohm_pkg;
    localparam int SEL_TRACE = 0;
    localparam int SEL_FAULT = 1;
    localparam int SEL_PROT  = 2;
    localparam int BYTE_W    = 8;
    localparam int PROT_LO_W = 5;
    localparam int CNT_W     = 4;

    function automatic int field_width(input int sel);
        return (sel == SEL_PROT) ? BYTE_W + PROT_LO_W : BYTE_W;
    endfunction
endpackage

// File: rtl/ohm_extract.sv
module ohm_extract
    import ohm_pkg::*;
#(
    parameter int FIELD_SEL = SEL_PROT,
    localparam int FW = field_width(FIELD_SEL)
) (
    input  logic [BYTE_W-1:0] byte_a_i,
    input  logic [BYTE_W-1:0] byte_b_i,
    output logic [FW-1:0]     field_o
);
    generate
        if (FIELD_SEL == SEL_PROT) begin : g_prot
            logic unused_lo;
            assign unused_lo = ^byte_b_i[BYTE_W-PROT_LO_W-1:0];
            assign field_o   = {byte_a_i, byte_b_i[BYTE_W-1:BYTE_W-PROT_LO_W]};
        end else begin : g_byte
            logic unused_b;
            assign unused_b = ^byte_b_i;
            assign field_o  = byte_a_i;
        end
    endgenerate
endmodule

// File: rtl/ohm_filter.sv
module ohm_filter
    import ohm_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [FW-1:0]    field_i,
    input  logic [CNT_W-1:0] cfg_cnt_i,
    output logic [FW-1:0]    acc_o,
    output logic             accept_o
);
    typedef struct packed {
        logic [FW-1:0]    cand;
        logic [CNT_W-1:0] cnt;
        logic [FW-1:0]    acc;
    } flt_state_t;

    flt_state_t s_d, s_q;
    logic [CNT_W-1:0] thr_d;

    always_comb begin
        s_d      = s_q;
        accept_o = 1'b0;
        thr_d    = (cfg_cnt_i == '0) ? CNT_W'(1) : cfg_cnt_i;
        if (stb_i) begin
            if (field_i != s_q.cand) begin
                s_d.cand = field_i;
                s_d.cnt  = CNT_W'(1);
            end else if (s_q.cnt != '1) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            if (s_d.cnt >= thr_d && s_d.cand != s_q.acc) begin
                s_d.acc  = s_d.cand;
                accept_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_o = s_q.acc;

    // R11
    acc_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.acc) |-> $past(stb_i));

    // R4
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (s_q.cnt != '0));
endmodule

// File: rtl/ohm_hist.sv
module ohm_hist #(
    parameter int FW      = 8,
    parameter bit HIST_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [FW-1:0] acc_i,
    output logic [FW-1:0] prev_o
);
    generate
        if (HIST_EN) begin : g_hist
            logic [FW-1:0] prev_d, prev_q;
            always_comb begin
                prev_d = prev_q;
                if (accept_i) prev_d = acc_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= prev_d;
            end
            assign prev_o = prev_q;
        end else begin : g_none
            logic unused_h;
            assign unused_h = ^{clk, rst_n, accept_i, acc_i};
            assign prev_o   = '0;
        end
    endgenerate
endmodule

// File: rtl/ohm_flag.sv
module ohm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i)      flag_d = 1'b1;
        else if (clr_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ~mask_i;

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_i));
endmodule

// File: rtl/ohm_persist_mon.sv
module ohm_persist_mon
    import ohm_pkg::*;
#(
    parameter int FIELD_SEL = SEL_PROT,
    localparam int FW = field_width(FIELD_SEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [7:0]       ovh_a,
    input  logic [7:0]       ovh_b,
    input  logic [3:0]       persist_cfg,
    input  logic             chg_mask,
    input  logic             chg_clear,
    output logic [FW-1:0]    acc_value,
    output logic [FW-1:0]    prev_value,
    output logic             chg_flag,
    output logic             chg_irq
);
    localparam bit HIST_EN = (FIELD_SEL == SEL_FAULT);

    logic [FW-1:0] field_w;
    logic          accept_w;

    ohm_extract #(.FIELD_SEL(FIELD_SEL)) u_ext (
        .byte_a_i (ovh_a),
        .byte_b_i (ovh_b),
        .field_o  (field_w)
    );

    ohm_filter #(.FW(FW)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (frame_stb),
        .field_i   (field_w),
        .cfg_cnt_i (persist_cfg),
        .acc_o     (acc_value),
        .accept_o  (accept_w)
    );

    ohm_hist #(.FW(FW), .HIST_EN(HIST_EN)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept_w),
        .acc_i    (acc_value),
        .prev_o   (prev_value)
    );

    ohm_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (accept_w),
        .clr_i  (chg_clear),
        .mask_i (chg_mask),
        .flag_o (chg_flag),
        .irq_o  (chg_irq)
    );

    // R8 R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> chg_flag);

    generate
        if (HIST_EN) begin : g_hist_chk
            // R6
            hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_value != $past(acc_value)) |-> (prev_value == $past(acc_value)));
        end
    endgenerate
endmodule

// File: tb/sim_ohm_persist_mon.sv
module sim_ohm_persist_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [7:0]  ovh_a = '0;
    logic [7:0]  ovh_b = '0;
    logic [3:0]  persist_cfg = '0;
    logic        chg_mask = 1'b0;
    logic        chg_clear = 1'b0;

    logic [7:0]  acc0, prev0;
    logic [12:0] acc1, prev1;
    logic        flag0, irq0, flag1, irq1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ohm_persist_mon #(.FIELD_SEL(1)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ovh_a(ovh_a), .ovh_b(ovh_b),
        .persist_cfg(persist_cfg), .chg_mask(chg_mask), .chg_clear(chg_clear),
        .acc_value(acc0), .prev_value(prev0), .chg_flag(flag0), .chg_irq(irq0));

    ohm_persist_mon #(.FIELD_SEL(2)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ovh_a(ovh_a), .ovh_b(ovh_b),
        .persist_cfg(persist_cfg), .chg_mask(chg_mask), .chg_clear(chg_clear),
        .acc_value(acc1), .prev_value(prev1), .chg_flag(flag1), .chg_irq(irq1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic clr);
        @(negedge clk);
        frame_stb = 1'b1; ovh_a = a; ovh_b = b; chg_clear = clr;
        @(negedge clk);
        frame_stb = 1'b0; chg_clear = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        chg_clear = 1'b1;
        @(negedge clk);
        chg_clear = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  eacc0, eprev0;
        logic [12:0] eacc1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc", 32'(acc0), 0);
        check("R1 prev", 32'(prev0), 0);
        check("R1 flag", 32'(flag0), 0);
        check("R1 acc13", 32'(acc1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        eacc0 = '0; eprev0 = '0; eacc1 = '0;

        // R2 R3 R6 R7 R8: sweep every persistence setting
        for (int c = 0; c < 16; c++) begin
            int thr;
            logic [7:0] a, b;
            thr = (c == 0) ? 1 : c;
            a = 8'(c + 1);
            b = 8'((c * 37) | 8'h08);
            persist_cfg = 4'(c);
            clear_flag();
            for (int k = 1; k <= thr; k++) begin
                frame(a, b, 1'b0);
                if (k < thr) begin
                    check("R2 early acc", 32'(acc0), 32'(eacc0));
                    check("R2 early flag", 32'(flag0), 0);
                end else begin
                    eprev0 = eacc0; eacc0 = a; eacc1 = {a, b[7:3]};
                    check(c == 0 ? "R3 acc" : "R2 acc", 32'(acc0), 32'(eacc0));
                    check("R6 prev", 32'(prev0), 32'(eprev0));
                    check("R6 prev13 zero", 32'(prev1), 0);
                    check("R7 acc13", 32'(acc1), 32'(eacc1));
                    check("R8 flag set", 32'(flag0), 1);
                end
            end
        end

        // R8 sticky, R10 mask
        repeat (4) @(negedge clk);
        check("R8 sticky", 32'(flag0), 1);
        check("R10 irq unmasked", 32'(irq0), 1);
        chg_mask = 1'b1; #1;
        check("R10 irq masked", 32'(irq0), 0);
        chg_mask = 1'b0;
        clear_flag();
        check("R8 cleared", 32'(flag0), 0);
        check("R10 irq no flag", 32'(irq0), 0);

        // R4 interrupted run
        persist_cfg = 4'd3;
        frame(8'hA5, 8'h10, 1'b0);
        frame(8'hA5, 8'h10, 1'b0);
        frame(8'h5A, 8'h10, 1'b0);
        frame(8'hA5, 8'h10, 1'b0);
        frame(8'hA5, 8'h10, 1'b0);
        check("R4 no accept", 32'(acc0), 32'(eacc0));
        frame(8'hA5, 8'h10, 1'b0);
        eprev0 = eacc0; eacc0 = 8'hA5;
        check("R4 accept after full run", 32'(acc0), 32'hA5);
        check("R6 prev", 32'(prev0), 32'(eprev0));

        // R11 idle cycles keep the run
        persist_cfg = 4'd2;
        clear_flag();
        frame(8'h3C, 8'h10, 1'b0);
        @(negedge clk);
        ovh_a = 8'h5A;
        repeat (3) @(negedge clk);
        check("R11 idle no change", 32'(acc0), 32'hA5);
        frame(8'h3C, 8'h10, 1'b0);
        eprev0 = eacc0; eacc0 = 8'h3C;
        check("R11 run kept", 32'(acc0), 32'h3C);

        // R5 accepted value repeated
        clear_flag();
        persist_cfg = 4'd1;
        frame(8'h3C, 8'h10, 1'b0);
        check("R5 acc", 32'(acc0), 32'h3C);
        check("R5 flag", 32'(flag0), 0);
        persist_cfg = 4'd2;
        frame(8'h66, 8'h10, 1'b0);
        frame(8'h3C, 8'h10, 1'b0);
        frame(8'h3C, 8'h10, 1'b0);
        check("R5 prev kept", 32'(prev0), 32'(eprev0));
        check("R5 flag still", 32'(flag0), 0);

        // R7 low byte ignored in byte variant, used in protection variant
        frame(8'h77, 8'h10, 1'b0);
        frame(8'h77, 8'hF0, 1'b0);
        check("R7 byte b ignored", 32'(acc0), 32'h77);
        check("R7 prot run broken", 32'(acc1), 32'({8'h3C, 5'h02}));

        // R9 set wins over clear
        persist_cfg = 4'd1;
        clear_flag();
        frame(8'h99, 8'h10, 1'b1);
        check("R9 set wins", 32'(flag0), 1);
        clear_flag();
        check("R9 later clear", 32'(flag0), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule